// File: doc/BRIEF.md
# Serial Port Transmit/Receive Queue Pair

This block sits between a register bus and a serial shift engine. It holds two word queues: one carries words from the bus toward the engine for transmission, and the other carries words the engine has received back toward the bus. The bus side writes transmit words and reads received words through one-cycle strobes. The engine side removes transmit words and adds received words through its own strobes. The shifting of bits on the wire happens elsewhere.

Around the queues the block builds a 15-bit status word and a 4-bit set of latched interrupt sources. For each queue the status word gives the full and empty flags and two lookahead flags. One lookahead flag says that a single further write will fill the queue. The other says that a single further read will empty it. The sources are transmit done, receive ready, receive overflow and transmit underrun. Each source stays set until software writes a 1 to its bit of the clear vector. A per-source enable produces the masked vector, and the OR of the masked vector drives one interrupt line. Separate single-cycle command strobes empty either queue.

Top module: `spi_fifo_pair`

## Requirements
- R1: Words written by the bus come out on `engTxData` in the order written, one per engine pop, up to DEPTH words held at once.
- R2: A bus write while the transmit queue holds DEPTH words is ignored: the stored words are unchanged and the extra word never reaches the engine.
- R3: An engine push while the receive queue holds DEPTH words drops the word and sets raw source bit 2 (receive overflow).
- R4: While the receive queue is empty, `busRdData` reads zero. A read strobe then changes neither the queue nor any source. `engTxData` likewise reads zero while the transmit queue is empty.
- R5: The status queue flags sit at these positions. Bit 4 is receive full, bit 5 is receive holding DEPTH-1, bit 6 is receive empty and bit 7 is receive holding exactly one. Bit 8 is transmit full, bit 9 is transmit holding DEPTH-1, bit 10 is transmit empty and bit 11 is transmit holding exactly one.
- R6: An engine pop while the transmit queue is empty sets raw source bit 3 (transmit underrun).
- R7: A successful engine pop sets raw source bit 0 (transmit done), and an accepted engine push sets raw source bit 1 (receive ready). Status bits 0 to 3 mirror raw source bits 0 to 3.
- R8: A raw source stays set until a cycle with its `intClear` bit at 1. Clearing one bit leaves the others untouched. A set and a clear of the same bit in the same cycle leave the bit set.
- R9: `maskInt` equals `rawInt` ANDed with `intEnable` bit by bit, and `irq` is high exactly when `maskInt` is nonzero.
- R10: `cmdTxReset` and `cmdRxReset` each empty only their own queue within one cycle. A push or pop in the same cycle as the reset of that queue has no effect and sets no source.
- R11: Status bits 12, 13 and 14 show the engine's frame-start, select-active and busy inputs.
- R12: After reset both queues are empty, every source is clear, `irq` is low and the status word is 15'h0440 (with the engine inputs low).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrValid | input | 1 | Bus strobe that writes one transmit word |
| busWrData | input | WIDTH | Transmit word from the bus |
| busRdStrobe | input | 1 | Bus strobe that consumes one received word |
| busRdData | output | WIDTH | Oldest received word, zero when empty |
| engPop | input | 1 | Engine takes one transmit word |
| engTxData | output | WIDTH | Oldest transmit word, zero when empty |
| engPush | input | 1 | Engine delivers one received word |
| engRxData | input | WIDTH | Received word from the engine |
| engFrameStart | input | 1 | Engine is at the start of a frame |
| engSelect | input | 1 | Engine has a target selected |
| engBusy | input | 1 | Engine is shifting a transfer |
| cmdTxReset | input | 1 | Single-cycle strobe that empties the transmit queue |
| cmdRxReset | input | 1 | Single-cycle strobe that empties the receive queue |
| intEnable | input | 4 | Per-source interrupt enables |
| intClear | input | 4 | Write-one-to-clear strobes for the sources |
| status | output | 15 | Status word |
| rawInt | output | 4 | Latched interrupt sources |
| maskInt | output | 4 | Enabled interrupt sources |
| irq | output | 1 | OR of the enabled sources |

## Verification
The embedded properties check on every cycle that a full transmit queue holds its level against a lone bus write and that each queue's level stays within its depth. They also check that neither store sees a write when full or a read when empty, that a push into a full receive queue and a pop from an empty transmit queue raise their sources a cycle later, that latched sources survive until cleared, and that a reset command leaves its queue empty. Only the directed scenarios can show data ordering through the queues, that the dropped and ignored words never reappear, the exact lookahead flag positions, and the interplay of enables, selective clears and same-cycle set-versus-clear on the interrupt line.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;

  // interrupt source positions (also status bits 0..3)
  localparam int IX_TX_DONE  = 0;
  localparam int IX_RX_READY = 1;
  localparam int IX_RX_OVF   = 2;
  localparam int IX_TX_UDR   = 3;
  localparam int NUM_SRC     = 4;
  localparam int STATUS_W    = 15;

  // strobes from control to datapath
  typedef struct packed {
    logic txWr;
    logic txRd;
    logic rxWr;
    logic rxRd;
    logic txClr;
    logic rxClr;
  } fifoStrobes_t;

endpackage

// File: rtl/spi_fifo_store.sv
module spi_fifo_store #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       clr,
  input  logic                       wr,
  input  logic [WIDTH-1:0]           wrData,
  input  logic                       rd,
  output logic [WIDTH-1:0]           rdData,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (clr) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (wr) wrPtr <= bump(wrPtr);
      if (rd) rdPtr <= bump(rdPtr);
      case ({wr, rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (wr && !clr) mem[wrPtr] <= wrData;
  end

  assign rdData = mem[rdPtr];

  // R2/R3: control never writes a full store
  a_r2_no_write_full: assert property (@(posedge clk) disable iff (!rstN)
    wr |-> (count != FULL_CNT));
  // R4: control never reads an empty store
  a_r4_no_read_empty: assert property (@(posedge clk) disable iff (!rstN)
    rd |-> (count != '0));
  // R1: level never exceeds the depth
  a_r1_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT);

endmodule

// File: rtl/spi_fifo_dp.sv
module spi_fifo_dp
  import spi_fifo_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int DEPTH = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  fifoStrobes_t               strb,
  input  logic [WIDTH-1:0]           busWrData,
  input  logic [WIDTH-1:0]           engRxData,
  output logic [WIDTH-1:0]           busRdData,
  output logic [WIDTH-1:0]           engTxData,
  output logic [$clog2(DEPTH+1)-1:0] txCount,
  output logic [$clog2(DEPTH+1)-1:0] rxCount
);
  logic [WIDTH-1:0] txHead;
  logic [WIDTH-1:0] rxHead;

  spi_fifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) txStore (
    .clk    (clk),
    .rstN   (rstN),
    .clr    (strb.txClr),
    .wr     (strb.txWr),
    .wrData (busWrData),
    .rd     (strb.txRd),
    .rdData (txHead),
    .count  (txCount)
  );

  spi_fifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) rxStore (
    .clk    (clk),
    .rstN   (rstN),
    .clr    (strb.rxClr),
    .wr     (strb.rxWr),
    .wrData (engRxData),
    .rd     (strb.rxRd),
    .rdData (rxHead),
    .count  (rxCount)
  );

  // empty queues present zero instead of stale storage
  assign busRdData = (rxCount == '0) ? '0 : rxHead;
  assign engTxData = (txCount == '0) ? '0 : txHead;

endmodule

// File: rtl/spi_fifo_ctrl.sv
module spi_fifo_ctrl
  import spi_fifo_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       busWrValid,
  input  logic                       busRdStrobe,
  input  logic                       engPop,
  input  logic                       engPush,
  input  logic                       engFrameStart,
  input  logic                       engSelect,
  input  logic                       engBusy,
  input  logic                       cmdTxReset,
  input  logic                       cmdRxReset,
  input  logic [NUM_SRC-1:0]         intEnable,
  input  logic [NUM_SRC-1:0]         intClear,
  input  logic [$clog2(DEPTH+1)-1:0] txCount,
  input  logic [$clog2(DEPTH+1)-1:0] rxCount,
  output fifoStrobes_t               strb,
  output logic [STATUS_W-1:0]        status,
  output logic [NUM_SRC-1:0]         rawInt,
  output logic [NUM_SRC-1:0]         maskInt,
  output logic                       irq
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] NEAR_CNT = CNT_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

  logic txFull, txEmpty, rxFull, rxEmpty;
  logic [NUM_SRC-1:0] setVec;
  logic [NUM_SRC-1:0] rawReg;

  assign txFull  = (txCount == FULL_CNT);
  assign txEmpty = (txCount == '0);
  assign rxFull  = (rxCount == FULL_CNT);
  assign rxEmpty = (rxCount == '0);

  always_comb begin
    strb.txClr = cmdTxReset;
    strb.rxClr = cmdRxReset;
    strb.txWr  = busWrValid  && !txFull  && !cmdTxReset;
    strb.txRd  = engPop      && !txEmpty && !cmdTxReset;
    strb.rxWr  = engPush     && !rxFull  && !cmdRxReset;
    strb.rxRd  = busRdStrobe && !rxEmpty && !cmdRxReset;
  end

  always_comb begin
    setVec              = '0;
    setVec[IX_TX_DONE]  = strb.txRd;
    setVec[IX_RX_READY] = strb.rxWr;
    setVec[IX_RX_OVF]   = engPush && rxFull  && !cmdRxReset;
    setVec[IX_TX_UDR]   = engPop  && txEmpty && !cmdTxReset;
  end

  // set takes priority over a same-cycle clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rawReg <= '0;
    else       rawReg <= (rawReg & ~intClear) | setVec;
  end

  assign rawInt  = rawReg;
  assign maskInt = rawReg & intEnable;
  assign irq     = |maskInt;

  always_comb begin
    status       = '0;
    status[3:0]  = rawReg;
    status[4]    = rxFull;
    status[5]    = (rxCount == NEAR_CNT);
    status[6]    = rxEmpty;
    status[7]    = (rxCount == ONE_CNT);
    status[8]    = txFull;
    status[9]    = (txCount == NEAR_CNT);
    status[10]   = txEmpty;
    status[11]   = (txCount == ONE_CNT);
    status[12]   = engFrameStart;
    status[13]   = engSelect;
    status[14]   = engBusy;
  end

  // R2: full transmit queue keeps its level against a lone bus write
  a_r2_tx_hold_full: assert property (@(posedge clk) disable iff (!rstN)
    (txFull && busWrValid && !engPop && !cmdTxReset) |=> (txCount == FULL_CNT));
  // R3: push into a full receive queue raises overflow
  a_r3_overflow_sets: assert property (@(posedge clk) disable iff (!rstN)
    (engPush && rxFull && !cmdRxReset) |=> rawInt[IX_RX_OVF]);
  // R6: pop from an empty transmit queue raises underrun
  a_r6_underrun_sets: assert property (@(posedge clk) disable iff (!rstN)
    (engPop && txEmpty && !cmdTxReset) |=> rawInt[IX_TX_UDR]);
  // R8: uncleared sources survive
  a_r8_latched: assert property (@(posedge clk) disable iff (!rstN)
    ((rawReg & ~intClear) != '0) |=>
      ((rawReg & $past(rawReg & ~intClear)) == $past(rawReg & ~intClear)));
  // R10: reset commands leave their queue empty
  a_r10_tx_reset_empties: assert property (@(posedge clk) disable iff (!rstN)
    cmdTxReset |=> (txCount == '0));
  a_r10_rx_reset_empties: assert property (@(posedge clk) disable iff (!rstN)
    cmdRxReset |=> (rxCount == '0));

endmodule

// File: rtl/spi_fifo_pair.sv
module spi_fifo_pair
  import spi_fifo_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int DEPTH = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrValid,
  input  logic [WIDTH-1:0]  busWrData,
  input  logic              busRdStrobe,
  output logic [WIDTH-1:0]  busRdData,
  input  logic              engPop,
  output logic [WIDTH-1:0]  engTxData,
  input  logic              engPush,
  input  logic [WIDTH-1:0]  engRxData,
  input  logic              engFrameStart,
  input  logic              engSelect,
  input  logic              engBusy,
  input  logic              cmdTxReset,
  input  logic              cmdRxReset,
  input  logic [3:0]        intEnable,
  input  logic [3:0]        intClear,
  output logic [14:0]       status,
  output logic [3:0]        rawInt,
  output logic [3:0]        maskInt,
  output logic              irq
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  fifoStrobes_t     strb;
  logic [CNT_W-1:0] txCount;
  logic [CNT_W-1:0] rxCount;

  spi_fifo_ctrl #(.DEPTH(DEPTH)) ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .busWrValid    (busWrValid),
    .busRdStrobe   (busRdStrobe),
    .engPop        (engPop),
    .engPush       (engPush),
    .engFrameStart (engFrameStart),
    .engSelect     (engSelect),
    .engBusy       (engBusy),
    .cmdTxReset    (cmdTxReset),
    .cmdRxReset    (cmdRxReset),
    .intEnable     (intEnable),
    .intClear      (intClear),
    .txCount       (txCount),
    .rxCount       (rxCount),
    .strb          (strb),
    .status        (status),
    .rawInt        (rawInt),
    .maskInt       (maskInt),
    .irq           (irq)
  );

  spi_fifo_dp #(.WIDTH(WIDTH), .DEPTH(DEPTH)) dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .busWrData (busWrData),
    .engRxData (engRxData),
    .busRdData (busRdData),
    .engTxData (engTxData),
    .txCount   (txCount),
    .rxCount   (rxCount)
  );

endmodule

// File: tb/tb_spi_fifo_pair.sv
module tb_spi_fifo_pair;
  localparam int WIDTH = 32;
  localparam int DEPTH = 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              busWrValid = 1'b0;
  logic [WIDTH-1:0]  busWrData = '0;
  logic              busRdStrobe = 1'b0;
  logic [WIDTH-1:0]  busRdData;
  logic              engPop = 1'b0;
  logic [WIDTH-1:0]  engTxData;
  logic              engPush = 1'b0;
  logic [WIDTH-1:0]  engRxData = '0;
  logic              engFrameStart = 1'b0;
  logic              engSelect = 1'b0;
  logic              engBusy = 1'b0;
  logic              cmdTxReset = 1'b0;
  logic              cmdRxReset = 1'b0;
  logic [3:0]        intEnable = '0;
  logic [3:0]        intClear = '0;
  logic [14:0]       status;
  logic [3:0]        rawInt;
  logic [3:0]        maskInt;
  logic              irq;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  spi_fifo_pair #(.WIDTH(WIDTH), .DEPTH(DEPTH)) dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic busWrite(input logic [31:0] d);
    busWrValid = 1'b1; busWrData = d; tick(); busWrValid = 1'b0;
  endtask

  task automatic popCheck(input string req, input logic [31:0] exp);
    chk(req, engTxData, exp);
    engPop = 1'b1; tick(); engPop = 1'b0;
  endtask

  task automatic engWrite(input logic [31:0] d);
    engPush = 1'b1; engRxData = d; tick(); engPush = 1'b0;
  endtask

  task automatic readCheck(input string req, input logic [31:0] exp);
    chk(req, busRdData, exp);
    busRdStrobe = 1'b1; tick(); busRdStrobe = 1'b0;
  endtask

  task automatic clearAll();
    intClear = 4'hF; tick(); intClear = 4'h0;
  endtask

  task automatic t_reset();
    chk("R12 status", 32'(status), 32'h0440);
    chk("R12 raw", 32'(rawInt), 0);
    chk("R12 irq", 32'(irq), 0);
    chk("R4 tx empty data zero", engTxData, 0);
  endtask

  task automatic t_tx_order();
    busWrite(32'hA0);
    chk("R5 tx one-left flag", 32'(status[11:10]), 32'b10);
    busWrite(32'hA1);
    busWrite(32'hA2);
    popCheck("R1 order 0", 32'hA0);
    chk("R7 tx done set", 32'(rawInt[0]), 1);
    chk("R7 status mirrors", 32'(status[0]), 1);
    popCheck("R1 order 1", 32'hA1);
    popCheck("R1 order 2", 32'hA2);
    chk("R5 tx empty", 32'(status[10]), 1);
    clearAll();
  endtask

  task automatic t_tx_full();
    for (int i = 0; i < DEPTH - 1; i++) busWrite(32'h100 + i);
    chk("R5 tx near-full", 32'(status[9:8]), 32'b10);
    busWrite(32'h100 + DEPTH - 1);
    chk("R5 tx full", 32'(status[9:8]), 32'b01);
    busWrite(32'hDEAD);
    chk("R2 still full", 32'(status[8]), 1);
    for (int i = 0; i < DEPTH; i++) popCheck("R2 drain order", 32'h100 + i);
    chk("R2 extra word absent", engTxData, 0);
    chk("R5 tx empty after drain", 32'(status[10]), 1);
    engPop = 1'b1; tick(); engPop = 1'b0;
    chk("R6 underrun set", 32'(rawInt[3]), 1);
    clearAll();
  endtask

  task automatic t_rx();
    readCheck("R4 empty read zero", 0);
    chk("R4 still empty", 32'(status[6]), 1);
    chk("R4 no source", 32'(rawInt), 0);
    for (int i = 0; i < DEPTH - 1; i++) engWrite(32'h200 + i);
    chk("R5 rx near-full", 32'(status[5:4]), 32'b10);
    chk("R7 rx ready", 32'(rawInt[1]), 1);
    engWrite(32'h200 + DEPTH - 1);
    chk("R5 rx full", 32'(status[5:4]), 32'b01);
    chk("R3 no overflow yet", 32'(rawInt[2]), 0);
    engWrite(32'hBEEF);
    chk("R3 overflow set", 32'(rawInt[2]), 1);
    for (int i = 0; i < DEPTH; i++) begin
      if (i == DEPTH - 1) chk("R5 rx one-left", 32'(status[7:6]), 32'b10);
      readCheck("R3 rx order, dropped word absent", 32'h200 + i);
    end
    chk("R3 rx empty after drain", busRdData, 0);
    clearAll();
    chk("R8 clear all", 32'(rawInt), 0);
  endtask

  task automatic t_irq();
    engPop = 1'b1; tick(); engPop = 1'b0;
    chk("R9 raw underrun", 32'(rawInt), 32'h8);
    intEnable = 4'h0; #1;
    chk("R9 masked off", 32'(maskInt), 0);
    chk("R9 irq off", 32'(irq), 0);
    intEnable = 4'h8; #1;
    chk("R9 masked on", 32'(maskInt), 32'h8);
    chk("R9 irq on", 32'(irq), 1);
    engWrite(32'h55);
    intEnable = 4'h6; #1;
    chk("R9 partial mask", 32'(maskInt), 32'h2);
    intClear = 4'h8; tick(); intClear = 4'h0;
    chk("R8 selective clear", 32'(rawInt), 32'h2);
    intClear = 4'h2; tick(); intClear = 4'h0;
    chk("R9 irq drops", 32'(irq), 0);
    engPop = 1'b1; intClear = 4'h8; tick(); engPop = 1'b0; intClear = 4'h0;
    chk("R8 set beats clear", 32'(rawInt), 32'h8);
    intEnable = 4'h0;
    clearAll();
    readCheck("R8 leftover word", 32'h55);
  endtask

  task automatic t_fifo_reset();
    engWrite(32'h11); engWrite(32'h12);
    busWrite(32'h21); busWrite(32'h22);
    clearAll();
    cmdRxReset = 1'b1; engPush = 1'b1; engRxData = 32'h99;
    tick();
    cmdRxReset = 1'b0; engPush = 1'b0;
    chk("R10 rx emptied", 32'(status[6]), 1);
    chk("R10 tx untouched", 32'(status[10]), 0);
    chk("R10 no source on reset push", 32'(rawInt), 0);
    chk("R10 rx reads zero", busRdData, 0);
    cmdTxReset = 1'b1; engPop = 1'b1;
    tick();
    cmdTxReset = 1'b0; engPop = 1'b0;
    chk("R10 tx emptied", 32'(status[10]), 1);
    chk("R10 no source on reset pop", 32'(rawInt), 0);
  endtask

  task automatic t_engine_status();
    engFrameStart = 1'b1; engSelect = 1'b0; engBusy = 1'b1; #1;
    chk("R11 engine bits 101", 32'(status[14:12]), 32'b101);
    engFrameStart = 1'b0; engSelect = 1'b1; engBusy = 1'b0; #1;
    chk("R11 engine bits 010", 32'(status[14:12]), 32'b010);
    engSelect = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(); tick();
    rstN = 1'b1;
    tick();
    t_reset();
    t_tx_order();
    t_tx_full();
    t_rx();
    t_irq();
    t_fifo_reset();
    t_engine_status();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule